// File: doc/BRIEF.md
# Match Countdown Interrupt Timer

This block is a single-channel operating-system timer on a 32-bit word register bus. Software programs a target value; the block works out how many time-base ticks separate the target from the last value the counter reached, runs a one-shot countdown of that length, and on expiry moves the counter to the target. If interrupts are enabled at that moment, it latches a flag and drives an interrupt line until software clears the flag.

The time base is a tick-enable input, high for one cycle per 50 MHz period (every fourth cycle of a 200 MHz clock, or every cycle when the core clock itself runs at 50 MHz). Wraparound of the 32-bit counter is folded into the countdown length, so a target below the current counter schedules an event after the counter rolls over. The current counter position can be read back at any time as the target minus the remaining countdown. Clearing the flag takes a write of zero; any other value written there is rejected and reported on a one-cycle error pulse.

Register word offsets: 0x0 target (write-only, reads 0), 0x4 current counter (read-only), 0x8 flag (bit 0), 0xC interrupt enable (read/write, full word). Accesses whose two low address bits are not zero are not mapped.

Top module: `ost_timer`

## Requirements
- R1: After reset the counter (0x4), flag (0x8) and enable (0xC) registers read 0, and `irq` and `err` are low.
- R2: A write to offset 0x0 with a value above the counter register arms a countdown of (value minus counter) ticks; it decrements once per clock in which `tick` is high.
- R3: A write to offset 0x0 with a value not above the counter register arms a countdown of value + (0xFFFFFFFF minus counter) ticks.
- R4: A read of offset 0x4 returns the target minus the remaining countdown, in 32-bit modular arithmetic.
- R5: On the clock edge that applies the final tick, the counter register takes the target and the countdown stops; further ticks change nothing until offset 0x0 is written again.
- R6: If the enable register is non-zero at expiry, the flag (bit 0 of offset 0x8) and `irq` go high on the expiry edge and stay high until cleared.
- R7: If the enable register is zero at expiry, neither the flag nor `irq` is set, though the counter still takes the target.
- R8: Writing zero to offset 0x8 clears the flag and drops `irq` on that edge; an expiry on the same edge wins and keeps the flag set.
- R9: Writing a non-zero value to offset 0x8 leaves the flag unchanged and raises `err` for exactly the following cycle.
- R10: Offset 0xC holds the enable word as written (any non-zero value enables); offset 0x0 reads 0.
- R11: Rewriting offset 0x0 during a countdown restarts it, measured from the counter register (the value at the last expiry), not from the live readback.
- R12: In clocks with `tick` low and no bus write, the readback of offset 0x4 does not change.
- R13: Accesses with a non-zero low two address bits read 0 and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base enable, one pulse per timer tick |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Byte address of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid in the request cycle |
| irq | output | 1 | Interrupt request, high while the flag is set |
| err | output | 1 | One-cycle pulse after a rejected flag write |

## Verification
The checker watches, on every cycle, the local rules: a zero write to the flag drops the interrupt unless an expiry coincides, the interrupt otherwise holds, it only rises when enable was non-zero, a non-zero flag write and the error pulse imply each other, and the counter readback stays put without a tick or a write. Countdown lengths, the wraparound formula, the one-shot stop, the restart-from-last-expiry rule and the exact expiry cycle depend on long sequences of ticks and writes, so only the bench's directed scenarios, which count ticks and read back the counter, can show them.

// File: rtl/ost_pkg.sv
package ost_pkg;

    // Word offsets of the registers; the decode relies on them lying at
    // consecutive words starting at zero, in the order of reg_sel_e.
    localparam int OFF_TARGET = 'h0;
    localparam int OFF_COUNT  = 'h4;
    localparam int OFF_FLAG   = 'h8;
    localparam int OFF_ENABLE = 'hC;

    typedef enum logic [1:0] {
        REG_TARGET = 2'd0,
        REG_COUNT  = 2'd1,
        REG_FLAG   = 2'd2,
        REG_ENABLE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        logic     is_wr;
        reg_sel_e which;
    } bus_dec_t;

endpackage

// File: rtl/ost_decode.sv
module ost_decode #(
    parameter int ADDR_W = 4
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output ost_pkg::bus_dec_t dec
);
    import ost_pkg::*;

    logic aligned;
    logic in_range;

    always_comb begin
        aligned  = (addr[1:0] == 2'b00);
        in_range = ((addr >> 4) == '0);
        dec      = '0;
        if (sel && aligned && in_range) begin
            dec.hit   = 1'b1;
            dec.is_wr = wr;
            dec.which = reg_sel_e'(addr[3:2]);
        end
    end

endmodule

// File: rtl/ost_countdown.sv
module ost_countdown #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    output logic              expire,
    output logic [DATA_W-1:0] cur_value
);
    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    typedef struct packed {
        logic [DATA_W-1:0] target;
        logic [DATA_W-1:0] remain;
        logic [DATA_W-1:0] last;
        logic              run;
    } cd_state_t;

    cd_state_t st_d, st_q;

    // Countdown length from the last reached value to a new target,
    // folding the 32-bit rollover into the distance.
    function automatic logic [DATA_W-1:0] span(input logic [DATA_W-1:0] tgt,
                                               input logic [DATA_W-1:0] from);
        if (tgt > from) begin
            span = tgt - from;
        end else begin
            span = tgt + (ALL_ONES - from);
        end
    endfunction

    always_comb begin
        st_d   = st_q;
        // A zero-length span (target 0 from all-ones) also ends on the first tick.
        expire = st_q.run && tick && (st_q.remain <= {{(DATA_W-1){1'b0}}, 1'b1});
        if (st_q.run && tick) begin
            if (expire) begin
                st_d.remain = '0;
                st_d.run    = 1'b0;
                st_d.last   = st_q.target;
            end else begin
                st_d.remain = st_q.remain - 1'b1;
            end
        end
        if (load) begin
            st_d.target = load_val;
            st_d.remain = span(load_val, st_q.last);
            st_d.run    = 1'b1;
        end
        cur_value = st_q.target - st_q.remain;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ost_ctrl.sv
module ost_ctrl #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_flag,
    input  logic              wr_enable,
    input  logic [DATA_W-1:0] wdata,
    input  logic              expire,
    output logic [DATA_W-1:0] enable,
    output logic              flag,
    output logic              err
);
    typedef struct packed {
        logic [DATA_W-1:0] enable;
        logic              flag;
        logic              err;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (wr_enable) begin
            st_d.enable = wdata;
        end
        if (wr_flag) begin
            if (wdata == '0) begin
                st_d.flag = 1'b0;
            end else begin
                st_d.err = 1'b1;
            end
        end
        // An event on the same edge as a clear is kept.
        if (expire && (st_q.enable != '0)) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign enable = st_q.enable;
    assign flag   = st_q.flag;
    assign err    = st_q.err;

endmodule

// File: rtl/ost_timer.sv
module ost_timer #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              err
);
    import ost_pkg::*;

    bus_dec_t          dec;
    logic              wr_target;
    logic              wr_flag;
    logic              wr_enable;
    logic              cd_expire;
    logic [DATA_W-1:0] cur_value;
    logic [DATA_W-1:0] enable_q;
    logic              flag_q;

    ost_decode #(.ADDR_W(ADDR_W)) u_dec (
        .sel  (bus_sel),
        .wr   (bus_wr),
        .addr (bus_addr),
        .dec  (dec)
    );

    always_comb begin
        wr_target = dec.hit && dec.is_wr && (dec.which == REG_TARGET);
        wr_flag   = dec.hit && dec.is_wr && (dec.which == REG_FLAG);
        wr_enable = dec.hit && dec.is_wr && (dec.which == REG_ENABLE);
    end

    ost_countdown #(.DATA_W(DATA_W)) u_cd (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .load      (wr_target),
        .load_val  (bus_wdata),
        .expire    (cd_expire),
        .cur_value (cur_value)
    );

    ost_ctrl #(.DATA_W(DATA_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_flag   (wr_flag),
        .wr_enable (wr_enable),
        .wdata     (bus_wdata),
        .expire    (cd_expire),
        .enable    (enable_q),
        .flag      (flag_q),
        .err       (err)
    );

    always_comb begin
        bus_rdata = '0;
        if (dec.hit && !dec.is_wr) begin
            unique case (dec.which)
                REG_TARGET: bus_rdata = '0;
                REG_COUNT:  bus_rdata = cur_value;
                REG_FLAG:   bus_rdata = {{(DATA_W-1){1'b0}}, flag_q};
                REG_ENABLE: bus_rdata = enable_q;
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign irq = flag_q;

endmodule

// File: rtl/ost_timer_chk.sv
module ost_timer_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq,
    input logic              err,
    input logic              expire,
    input logic [DATA_W-1:0] cur_value,
    input logic [DATA_W-1:0] enable
);
    logic flag_wr;
    logic clear_wr;
    logic bad_wr;
    logic any_wr;

    always_comb begin
        flag_wr  = bus_sel && bus_wr && (bus_addr == ADDR_W'(ost_pkg::OFF_FLAG));
        clear_wr = flag_wr && (bus_wdata == '0);
        bad_wr   = flag_wr && (bus_wdata != '0);
        any_wr   = bus_sel && bus_wr;
    end

    p_clear_drops_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_wr && !expire) |=> !irq);

    p_irq_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clear_wr) |=> irq);

    p_irq_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(expire) && ($past(enable) != '0)));

    p_bad_flag_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr |=> err);

    p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(bad_wr));

    p_idle_value_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !any_wr) |=> $stable(cur_value));

endmodule

bind ost_timer ost_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .err       (err),
    .expire    (cd_expire),
    .cur_value (cur_value),
    .enable    (enable_q)
);

// File: tb/sim_ost_timer.sv
`timescale 1ns/1ps
module sim_ost_timer;
    localparam int DW = 32;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq;
    logic          err;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    ost_timer #(.DATA_W(DW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .err(err)
    );

    task automatic chk(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        rd(4'h4, v); chk("R1", "count after reset", v, 0);
        rd(4'h8, v); chk("R1", "flag after reset", v, 0);
        rd(4'hC, v); chk("R1", "enable after reset", v, 0);
        chk("R1", "irq after reset", irq, 0);
        chk("R1", "err after reset", err, 0);
    endtask

    task automatic t_basic();
        logic [DW-1:0] v;
        wr(4'hC, 32'h1);
        rd(4'hC, v); chk("R10", "enable readback", v, 1);
        wr(4'h0, 32'd10);
        rd(4'h0, v); chk("R10", "target reads zero", v, 0);
        rd(4'h4, v); chk("R4", "count right after arm", v, 0);
        ticks(9);
        chk("R2", "irq before last tick", irq, 0);
        rd(4'h4, v); chk("R4", "count after 9 ticks", v, 9);
        ticks(1);
        chk("R6", "irq at expiry", irq, 1);
        rd(4'h8, v); chk("R6", "flag at expiry", v, 1);
        rd(4'h4, v); chk("R5", "count at expiry", v, 10);
        ticks(6);
        rd(4'h4, v); chk("R5", "count holds after expiry", v, 10);
        chk("R6", "irq holds", irq, 1);
    endtask

    task automatic t_bad_flag();
        logic [DW-1:0] v;
        wr(4'h8, 32'h5);
        chk("R9", "err after nonzero flag write", err, 1);
        chk("R9", "irq after nonzero flag write", irq, 1);
        @(negedge clk);
        chk("R9", "err one cycle only", err, 0);
        rd(4'h8, v); chk("R9", "flag unchanged", v, 1);
    endtask

    task automatic t_clear();
        logic [DW-1:0] v;
        wr(4'h8, 32'h0);
        chk("R8", "irq after clear", irq, 0);
        chk("R8", "no err on zero write", err, 0);
        rd(4'h8, v); chk("R8", "flag after clear", v, 0);
    endtask

    task automatic t_disabled();
        logic [DW-1:0] v;
        wr(4'hC, 32'h0);
        wr(4'h0, 32'd13);
        ticks(3);
        chk("R7", "no irq when disabled", irq, 0);
        rd(4'h8, v); chk("R7", "no flag when disabled", v, 0);
        rd(4'h4, v); chk("R7", "count still moves", v, 13);
        wr(4'hC, 32'h80);
        wr(4'h0, 32'd15);
        ticks(1);
        chk("R2", "irq early", irq, 0);
        ticks(1);
        chk("R10", "any nonzero enable works", irq, 1);
        wr(4'h8, 32'h0);
    endtask

    task automatic t_restart();
        logic [DW-1:0] v;
        wr(4'h0, 32'd30);
        ticks(5);
        rd(4'h4, v); chk("R11", "count mid run", v, 20);
        wr(4'h0, 32'd25);
        rd(4'h4, v); chk("R11", "count after rearm", v, 15);
        ticks(9);
        chk("R11", "irq not yet", irq, 0);
        ticks(1);
        chk("R11", "irq after 10", irq, 1);
        rd(4'h4, v); chk("R5", "count at new target", v, 25);
        wr(4'h8, 32'h0);
    endtask

    task automatic t_idle();
        logic [DW-1:0] v;
        wr(4'h0, 32'd40);
        rd(4'h4, v); chk("R12", "count before idle", v, 25);
        repeat (20) @(negedge clk);
        rd(4'h4, v); chk("R12", "count after idle", v, 25);
        chk("R12", "no irq while idle", irq, 0);
        ticks(15);
        chk("R2", "irq after 15", irq, 1);
        wr(4'h8, 32'h0);
    endtask

    task automatic t_wrap();
        logic [DW-1:0] v;
        wr(4'h0, 32'd4);
        rd(4'h4, v); chk("R3", "wrap target below counter", v, 41);
        ticks(3);
        rd(4'h4, v); chk("R3", "wrap after 3 ticks", v, 44);
        wr(4'h0, 32'd40);
        rd(4'h4, v); chk("R3", "target equal to counter", v, 41);
        chk("R3", "no irq on long run", irq, 0);
    endtask

    task automatic t_unmapped();
        logic [DW-1:0] v;
        wr(4'hD, 32'h0);
        rd(4'hC, v); chk("R13", "misaligned write ignored", v, 32'h80);
        wr(4'h9, 32'h7);
        chk("R13", "misaligned flag write no err", err, 0);
        rd(4'hE, v); chk("R13", "misaligned read zero", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_bad_flag();
        t_clear();
        t_disabled();
        t_restart();
        t_idle();
        t_wrap();
        t_unmapped();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        total++;
        bad++;
        $display("FAIL all: watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule